// File: doc/BRIEF.md
# Chunked Length Response Generator

The block takes length requests on a simple valid-qualified input and answers each one with a train of response chunks on a valid-qualified output. The chunk lengths of one request add up to exactly the requested length, and a last flag marks the final chunk of every request. No data moves through the block; it only produces the length bookkeeping a transfer engine or a protocol model would need.

Requests wait in an internal queue, so new requests can be accepted while an earlier one is still being answered, and answers come out strictly in request order. Each chunk is the smaller of the remaining length and a configured maximum. A configured number of idle cycles separates successive chunks. An abort strobe removes the oldest request that is still waiting in the queue, so that request never produces a response. A full flag shows that the queue cannot take more requests, and a sticky overflow flag records that a request was dropped because the queue was full.

Top module: `chunk_resp_gen`

## Requirements
- R1: After a synchronous reset, with no request issued, rsp_valid, rsp_last, full and overflow are all 0.
- R2: For every request, the chunk lengths up to and including the chunk with rsp_last=1 add up to the request length. Exactly one chunk per request has rsp_last=1, and rsp_last is never 1 without rsp_valid.
- R3: Each chunk length equals min(remaining, M). M is cfg_max_chunk, or 4 when cfg_max_chunk is 0. A chunk with rsp_last=0 therefore has a nonzero length.
- R4: A request of length 0 produces exactly one chunk, of length 0, with rsp_last=1.
- R5: Chunk trains leave in the order the requests were accepted. The queue holds 8 waiting requests, and requests are accepted while another request is being answered.
- R6: Between two chunks of the same request there are exactly cfg_gap idle cycles (0 to 7). Between any two chunks there are at least cfg_gap idle cycles.
- R7: An abort cycle (abort=1, req_valid=0) discards the oldest request that has not yet produced a chunk. It has no effect when no request is waiting. When req_valid=1, abort is ignored and the request is accepted.
- R8: full is 1 while 8 requests are waiting. A request presented while full=1 is dropped and produces no chunks. It sets overflow, which stays 1 until reset.
- R9: A reset in the middle of a chunk train stops that train and empties the queue. After the reset no further chunks appear and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_len | input | 32 | Requested total length |
| abort | input | 1 | Discard oldest waiting request (when req_valid=0) |
| cfg_max_chunk | input | 32 | Maximum chunk length; 0 selects 4 |
| cfg_gap | input | 3 | Idle cycles inserted after every chunk |
| rsp_valid | output | 1 | Chunk strobe |
| rsp_len | output | 32 | Chunk length |
| rsp_last | output | 1 | Final chunk of the current request |
| full | output | 1 | Queue holds 8 waiting requests |
| overflow | output | 1 | Sticky: a request was dropped while full |

## Verification
The assertions take for granted that cfg_max_chunk and cfg_gap stay constant while any request is queued or being answered. The chunk-size bound and the gap property compare output history against the current setting, so a change in mid-train would break them without any fault in the design. The bench changes configuration only after the monitor has seen every expected chunk train complete and the queue is drained. It also places aborts only at moments when the set of waiting requests is known from the timing it drives, such as after the first chunk of a long request has appeared.

// File: rtl/chunk_gen_pkg.sv
package chunk_gen_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SEND = 2'd1,
    ENG_WAIT = 2'd2
  } eng_state_t;

endpackage

// File: rtl/chunk_req_queue.sv
module chunk_req_queue #(
  parameter int LEN_W = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [LEN_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, count_nxt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop) count_nxt = count + 1'b1;
    else if (do_pop && !do_push) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_len;
  end

  assign head_len = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count <= count_nxt;
      empty <= (count_nxt == '0);
      full  <= (count_nxt == CNT_MAX);
      if (push && full) overflow <= 1'b1;
    end
  end

  // R5: never more waiting entries than the queue depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);
  // R8: a request refused for lack of room raises the sticky flag
  p_drop_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> overflow);
  // R8: the flag only clears by reset
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R5: a lone accepted push grows the occupancy by one
  p_push_counts_r5: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
  parameter int LEN_W     = 32,
  parameter int DEF_CHUNK = 4
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic [LEN_W-1:0] cfg_max,
  output logic [LEN_W-1:0] eff_max,
  output logic [LEN_W-1:0] chunk_len,
  output logic             chunk_last
);
  always_comb begin
    eff_max    = (cfg_max == '0) ? LEN_W'(DEF_CHUNK) : cfg_max;
    chunk_last = (remaining <= eff_max);
    chunk_len  = chunk_last ? remaining : eff_max;
  end
endmodule

// File: rtl/chunk_engine.sv
module chunk_engine
  import chunk_gen_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int GAP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_ready,
  input  logic [LEN_W-1:0] head_len,
  output logic             take_head,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic [LEN_W-1:0] remaining,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic             chunk_last,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_last
);
  eng_state_t       state;
  logic [GAP_W-1:0] gap_cnt;
  logic             resume;

  assign take_head = (state == ENG_IDLE) && head_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      gap_cnt   <= '0;
      resume    <= 1'b0;
      remaining <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_len   <= '0;
      unique case (state)
        ENG_IDLE: begin
          if (head_ready) begin
            remaining <= head_len;
            state     <= ENG_SEND;
          end
        end
        ENG_SEND: begin
          rsp_valid <= 1'b1;
          rsp_len   <= chunk_len;
          rsp_last  <= chunk_last;
          remaining <= remaining - chunk_len;
          resume    <= !chunk_last;
          gap_cnt   <= cfg_gap;
          if (cfg_gap != '0) state <= ENG_WAIT;
          else if (chunk_last) state <= ENG_IDLE;
        end
        ENG_WAIT: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == GAP_W'(1)) state <= resume ? ENG_SEND : ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R6: a nonzero gap forbids back-to-back chunks
  p_gap_respected_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cfg_gap != '0) |=> !rsp_valid);
  // R3: a chunk that is not final carries a nonzero length
  p_nonfinal_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_last) |-> rsp_len != '0);
  // R9: reset silences the output on the following cycle
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !rsp_valid);

endmodule

// File: rtl/chunk_resp_gen.sv
module chunk_resp_gen #(
  parameter int LEN_W     = 32,
  parameter int DEPTH     = 8,
  parameter int GAP_W     = 3,
  parameter int DEF_CHUNK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             abort,
  input  logic [LEN_W-1:0] cfg_max_chunk,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             rsp_valid,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_last,
  output logic             full,
  output logic             overflow
);
  logic             q_empty, abort_pop, take_head, head_ready;
  logic [LEN_W-1:0] head_len, remaining, eff_max, chunk_len;
  logic             chunk_last;

  // abort only counts on a cycle without a request, and beats the engine
  assign abort_pop  = abort && !req_valid && !q_empty;
  assign head_ready = !q_empty && !abort_pop;

  chunk_req_queue #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (req_valid),
    .push_len (req_len),
    .pop      (abort_pop || take_head),
    .head_len (head_len),
    .empty    (q_empty),
    .full     (full),
    .overflow (overflow)
  );

  chunk_sizer #(.LEN_W(LEN_W), .DEF_CHUNK(DEF_CHUNK)) u_sizer (
    .remaining  (remaining),
    .cfg_max    (cfg_max_chunk),
    .eff_max    (eff_max),
    .chunk_len  (chunk_len),
    .chunk_last (chunk_last)
  );

  chunk_engine #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .head_ready (head_ready),
    .head_len   (head_len),
    .take_head  (take_head),
    .cfg_gap    (cfg_gap),
    .remaining  (remaining),
    .chunk_len  (chunk_len),
    .chunk_last (chunk_last),
    .rsp_valid  (rsp_valid),
    .rsp_len    (rsp_len),
    .rsp_last   (rsp_last)
  );

  // R2: the final marker only travels with a valid chunk
  p_last_with_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);
  // R3: no chunk exceeds the effective maximum
  p_chunk_bound_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_len <= eff_max);
  // R7: engine and abort never take the same head entry
  p_single_pop_r7: assert property (@(posedge clk) disable iff (rst)
    !(abort_pop && take_head));

endmodule

// File: tb/chunk_resp_gen_bench.sv
module chunk_resp_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_len = '0;
  logic        abort = 1'b0;
  logic [31:0] cfg_max_chunk = '0;
  logic [2:0]  cfg_gap = '0;
  logic        rsp_valid, rsp_last, full, overflow;
  logic [31:0] rsp_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int unsigned exp_q[$];
  int unsigned cur_rem = 0;
  bit          cur_busy = 1'b0;
  bit          seen_any = 1'b0;
  bit          prev_last = 1'b0;
  int          idle_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_resp_gen u_chunk_resp_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .abort(abort), .cfg_max_chunk(cfg_max_chunk), .cfg_gap(cfg_gap),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_last(rsp_last),
    .full(full), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int unsigned act,
                       input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected requests and checks every chunk
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      cur_busy = 1'b0; seen_any = 1'b0; idle_cnt = 0;
    end else if (rsp_valid) begin
      int unsigned emax, elen;
      bit elast;
      if (seen_any) begin
        if (!prev_last)
          check(idle_cnt == int'(cfg_gap), "R6 gap inside request", idle_cnt, cfg_gap);
        else
          check(idle_cnt >= int'(cfg_gap), "R6 gap between requests", idle_cnt, cfg_gap);
      end
      if (!cur_busy) begin
        check(exp_q.size() != 0, "R5 unexpected chunk", rsp_len, 0);
        if (exp_q.size() != 0) begin
          cur_rem = exp_q.pop_front();
          cur_busy = 1'b1;
        end
      end
      emax  = (cfg_max_chunk == 0) ? 4 : cfg_max_chunk;
      elen  = (cur_rem < emax) ? cur_rem : emax;
      elast = (cur_rem <= emax);
      check(rsp_len == elen, "R3 chunk length", rsp_len, elen);
      check(rsp_last == elast, "R2 last flag", rsp_last, elast);
      cur_rem -= elen;
      if (elast) cur_busy = 1'b0;
      prev_last = rsp_last;
      seen_any = 1'b1;
      idle_cnt = 0;
    end else begin
      check(!rsp_last, "R2 last without valid", rsp_last, 0);
      idle_cnt++;
    end
  end

  task automatic send(input int unsigned len, input bit expect_accept);
    @(negedge clk);
    req_valid = 1'b1; req_len = len;
    if (expect_accept) exp_q.push_back(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || cur_busy) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0 && !cur_busy, req, exp_q.size(), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < WATCHDOG) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && !rsp_last, "R1 outputs idle", rsp_valid, 0);
    check(!full, "R1 full clear", full, 0);
    check(!overflow, "R1 overflow clear", overflow, 0);

    // R2 R3 single requests, default max (cfg 0 -> 4), no gap
    send(10, 1); drain("R2 request 10 answered");
    send(3, 1);  drain("R2 single-chunk request");
    // R4 zero length
    send(0, 1);  drain("R4 zero length answered");

    // R5 R6 overlapping requests, max 3, gap 2
    cfg_max_chunk = 3; cfg_gap = 3'd2;
    send(7, 1); send(5, 1); send(0, 1); send(9, 1);
    drain("R5 overlapping requests in order");

    // R6 largest gap, max 1
    cfg_max_chunk = 1; cfg_gap = 3'd7;
    send(4, 1); send(2, 1);
    drain("R6 gap 7");

    // R7 abort discards oldest waiting request
    cfg_max_chunk = 4; cfg_gap = 3'd3;
    send(20, 1);
    repeat (5) @(negedge clk);
    send(6, 1); send(11, 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    void'(exp_q.pop_front()); // the request of 6 is dropped
    drain("R7 aborted request silent");

    // R7 abort with empty queue is ignored
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    send(5, 1); drain("R7 abort on empty queue ignored");

    // R7 abort alongside a request is ignored
    send(16, 1);
    repeat (5) @(negedge clk);
    send(2, 1);
    @(negedge clk); req_valid = 1'b1; req_len = 3; abort = 1'b1;
    exp_q.push_back(3);
    @(negedge clk); req_valid = 1'b0; abort = 1'b0;
    drain("R7 abort with request ignored");

    // R8 full and overflow
    cfg_max_chunk = 1; cfg_gap = 3'd7;
    send(30, 1);
    repeat (5) @(negedge clk);
    for (int i = 1; i <= 8; i++) send(i, 1);
    check(full, "R8 full at 8 waiting", full, 1);
    check(!overflow, "R8 no overflow yet", overflow, 0);
    send(99, 0);
    check(overflow, "R8 overflow on drop", overflow, 1);
    drain("R8 dropped request silent");
    check(!full, "R8 full clears after drain", full, 0);
    check(overflow, "R8 overflow sticky", overflow, 1);

    // R9 reset mid-train
    cfg_max_chunk = 2; cfg_gap = 3'd1;
    send(40, 1); send(6, 1);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      int stray = 0;
      repeat (30) begin @(negedge clk); if (rsp_valid) stray++; end
      check(stray == 0, "R9 no chunks after reset", stray, 0);
    end
    check(!overflow && !full, "R9 flags cleared", overflow, 0);
    send(5, 1); drain("R9 operation after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule